// File: doc/BRIEF.md
# Write-Through Data Cache

This block is a direct-mapped data cache for the memory stage of a five-stage pipeline. It sits between the stage's load and store requests and a word-addressed main memory. It holds four lines, and each line is four 32-bit words. Loads that hit return their word in the same cycle. A load that misses raises a hold signal for a fixed three cycles. During that time the whole line is fetched from main memory through a line-wide read port, and then the word is returned.

Every store goes straight to main memory in the cycle it is presented, so main memory is always current. A store that hits also updates the cached copy. A store that misses leaves the cache alone and never stalls.

The block drives two hold outputs. The back-end hold freezes every pipeline stage during a load miss. The front-end hold is the same signal merged with an instruction-fetch miss input, so the fetch and decode stages stay frozen until both misses have cleared.

Top module: `dcache_wt`

## Requirements
- R1: After reset every line is invalid: `hold_all`, `hold_front` and `mem_we` are low, and the first load to any address misses.
- R2: A load (`rd_en`=1, `wr_en`=0) that hits returns the addressed word on `rdata` in the same cycle, with `hold_all` low.
- R3: A load that misses drives `hold_all` high for exactly three cycles, beginning with the request cycle. With the address held, the correct word appears on `rdata` in the fourth cycle, with `hold_all` low.
- R4: A miss refill loads all four words of the line, so that loads to the other three words of the same line then hit.
- R5: Word address bits [1:0] select the word, bits [3:2] select the line, and the bits above them form the tag. An access with the same line bits but a different tag replaces the line.
- R6: Every store drives `mem_we`=1, `mem_waddr`=address and `mem_wdata`=write data in the same cycle, without raising `hold_all`. Main memory therefore holds every stored value.
- R7: A store that hits also updates the cached word. A later load to that address hits and returns the new value.
- R8: A store that misses does not allocate a line. A later load to that address misses and fetches the stored value from main memory.
- R9: With `rd_en` and `wr_en` both low, no miss is raised and no memory write occurs.
- R10: `hold_front` is high whenever `hold_all` or `imiss` is high. When an instruction miss overlaps a load miss, `hold_front` stays high until both have ended.
- R11: A request with both `rd_en` and `wr_en` high is handled as a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 10 | Word address of the request |
| wdata | input | 32 | Store data |
| rd_en | input | 1 | Load request |
| wr_en | input | 1 | Store request |
| imiss | input | 1 | Instruction-fetch miss in progress |
| rdata | output | 32 | Load data, valid when a load is present and `hold_all` is low |
| hold_all | output | 1 | Holds every pipeline stage |
| hold_front | output | 1 | Holds the fetch and decode stages |
| mem_line_addr | output | 8 | Line address for the refill read |
| mem_line | input | 128 | Line read from main memory, word 0 in the lowest bits |
| mem_we | output | 1 | Main memory write strobe |
| mem_waddr | output | 10 | Main memory write address |
| mem_wdata | output | 32 | Main memory write data |

## Verification
Hit data, the hold outputs and the memory-write strobe are combinational, so they are due in the cycle the request is applied. The refilled word is due in the fourth cycle of a miss. The bench drives requests just after the falling edge and samples one time unit later. It keeps a load's address and enable steady and counts the sampled cycles in which `hold_all` is high, and it reads `rdata` only on the first sample with the hold released. This measures miss length and data timing against the three-cycle rule rather than against a fixed delay guess.

// File: rtl/dcache_wt.sv
module dcache_wt #(
  parameter int AW       = 10,
  parameter int DW       = 32,
  parameter int LINES    = 4,
  parameter int WPL      = 4,
  parameter int MISS_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              imiss,
  output logic [DW-1:0]     rdata,
  output logic              hold_all,
  output logic              hold_front,
  output logic [AW-$clog2(WPL)-1:0] mem_line_addr,
  input  logic [WPL*DW-1:0] mem_line,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DW-1:0]     mem_wdata
);
  localparam int WB = $clog2(WPL);
  localparam int IB = $clog2(LINES);
  localparam int TB = AW - WB - IB;
  localparam int CW = $clog2(MISS_CYC + 1);

  logic [DW-1:0] data_q [LINES][WPL];
  logic [TB-1:0] tag_q  [LINES];
  logic [LINES-1:0] vld_q;
  logic [CW-1:0] cnt_q;

  logic [WB-1:0] wsel;
  logic [IB-1:0] idx;
  logic [TB-1:0] tg;
  logic hit, is_load, busy, start, fill;

  assign wsel    = addr[WB-1:0];
  assign idx     = addr[WB+IB-1:WB];
  assign tg      = addr[AW-1:WB+IB];
  assign hit     = vld_q[idx] && (tag_q[idx] == tg);
  assign is_load = rd_en && !wr_en;
  assign busy    = (cnt_q != '0);
  assign start   = is_load && !hit && !busy;
  assign fill    = busy && (cnt_q == CW'(1));

  assign hold_all      = start || busy;
  assign hold_front    = hold_all || imiss;
  assign rdata         = (is_load && hit && !busy) ? data_q[idx][wsel] : '0;
  assign mem_line_addr = addr[AW-1:WB];
  assign mem_we        = wr_en && !busy;
  assign mem_waddr     = addr;
  assign mem_wdata     = wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= '0;
    end else begin
      if (start)     cnt_q <= CW'(MISS_CYC - 1);
      else if (busy) cnt_q <= cnt_q - CW'(1);
      if (fill) vld_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q[idx] <= tg;
      for (int w = 0; w < WPL; w++) data_q[idx][w] <= mem_line[w*DW +: DW];
    end else if (mem_we && hit) begin
      data_q[idx][wsel] <= wdata;
    end
  end

  a_r3_miss_len: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_all && $past(hold_all) && $past(hold_all, 2)) |=> !hold_all);
  a_r3_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !$past(hold_all)) |=> hold_all);
  a_r4_fill_hits: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> hit);
  a_r6_store_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |-> !hold_all);
  a_r7_store_hit_update: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && hit) |=> data_q[$past(idx)][$past(wsel)] == $past(wdata));
  a_r8_no_allocate: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !hit) |=> $stable(vld_q));
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en && !busy) |-> (!hold_all && !mem_we));
endmodule

// File: tb/dcache_wt_tb.sv
module dcache_wt_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rd_en = 0, wr_en = 0, imiss = 0;
  logic [31:0] rdata;
  logic hold_all, hold_front, mem_we;
  logic [7:0] mem_line_addr;
  logic [127:0] mem_line;
  logic [9:0] mem_waddr;
  logic [31:0] mem_wdata;

  logic [31:0] mem    [1024];
  logic [31:0] golden [1024];

  typedef struct { string req; logic [31:0] val; } item_t;
  item_t exp_q[$];
  item_t obs_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcache_wt u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en),
    .wr_en(wr_en), .imiss(imiss), .rdata(rdata), .hold_all(hold_all),
    .hold_front(hold_front), .mem_line_addr(mem_line_addr), .mem_line(mem_line),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata));

  assign mem_line = {mem[{mem_line_addr, 2'd3}], mem[{mem_line_addr, 2'd2}],
                     mem[{mem_line_addr, 2'd1}], mem[{mem_line_addr, 2'd0}]};

  always @(posedge clk) if (mem_we) mem[mem_waddr] <= mem_wdata;

  task automatic expect_val(string req, logic [31:0] act, logic [31:0] exp);
    exp_q.push_back('{req, exp});
    obs_q.push_back('{req, act});
  endtask

  task automatic drain();
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      item_t e = exp_q.pop_front();
      item_t o = obs_q.pop_front();
      checks++;
      if (o.val !== e.val) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", e.req, o.val, e.val);
      end
    end
  endtask

  always @(negedge clk) if (!done) drain();

  task automatic load(logic [9:0] a, int exp_hold, string req);
    int n = 0;
    @(negedge clk);
    addr = a; rd_en = 1; wr_en = 0;
    #1;
    while (hold_all && n < 20) begin
      n++;
      @(negedge clk); #1;
    end
    expect_val({req, " hold cycles"}, 32'(n), 32'(exp_hold));
    expect_val({req, " data"}, rdata, golden[a]);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic store(logic [9:0] a, logic [31:0] d, logic also_rd, string req);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1; rd_en = also_rd;
    #1;
    expect_val({req, " no hold"}, 32'(hold_all), 32'd0);
    expect_val({req, " mem_we"}, 32'(mem_we), 32'd1);
    expect_val({req, " waddr"}, 32'(mem_waddr), 32'(a));
    expect_val({req, " wdata"}, mem_wdata, d);
    golden[a] = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 32'hA000_0000 + 32'(i);
      golden[i] = 32'hA000_0000 + 32'(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    expect_val("R1 reset hold_all", 32'(hold_all), 0);
    expect_val("R1 reset hold_front", 32'(hold_front), 0);
    expect_val("R1 reset mem_we", 32'(mem_we), 0);

    load(10'h010, 3, "R1 R3 first load miss");
    load(10'h011, 0, "R2 R4 hit word1");
    load(10'h012, 0, "R4 hit word2");
    load(10'h013, 0, "R4 hit word3");
    load(10'h014, 3, "R5 line1 miss");
    load(10'h020, 3, "R5 line0 new tag");
    load(10'h010, 3, "R5 evicted refetch");

    store(10'h011, 32'hDEAD_BEEF, 0, "R6 R7 store hit");
    load(10'h011, 0, "R7 load after store hit");

    store(10'h035, 32'h1234_5678, 0, "R6 R8 store miss");
    load(10'h014, 0, "R8 line1 not replaced");
    load(10'h035, 3, "R8 load after store miss");

    @(negedge clk); #1;
    expect_val("R9 idle hold", 32'(hold_all), 0);
    expect_val("R9 idle mem_we", 32'(mem_we), 0);

    store(10'h012, 32'hCAFE_0012, 1, "R11 rd+wr as store");
    load(10'h012, 0, "R11 stored value");

    @(negedge clk);
    imiss = 1; #1;
    expect_val("R10 imiss alone front", 32'(hold_front), 1);
    expect_val("R10 imiss alone all", 32'(hold_all), 0);
    addr = 10'h040; rd_en = 1; #1;
    for (int c = 0; c < 3; c++) begin
      expect_val("R10 overlap all", 32'(hold_all), 1);
      expect_val("R10 overlap front", 32'(hold_front), 1);
      @(negedge clk); #1;
    end
    expect_val("R10 dmiss ended", 32'(hold_all), 0);
    expect_val("R10 front held by imiss", 32'(hold_front), 1);
    expect_val("R3 data after overlap", rdata, golden[10'h040]);
    @(negedge clk); rd_en = 0; imiss = 0; #1;
    expect_val("R10 front released", 32'(hold_front), 0);

    @(negedge clk);
    expect_val("R6 main mem 011", mem[10'h011], 32'hDEAD_BEEF);
    expect_val("R6 main mem 035", mem[10'h035], 32'h1234_5678);
    expect_val("R6 main mem 012", mem[10'h012], 32'hCAFE_0012);

    @(negedge clk);
    drain();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      drain();
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule